// File: doc/BRIEF.md
# Banked EPROM Read Sequencer

This block sits between a host that issues word reads and a bank of 16-bit asynchronous EPROMs sharing one data bus. The host presents a flat address; its top bits pick one device and the remaining bits go to the shared address pins. Each device has its own active-low chip select. Only the addressed device is selected and every other device stays in standby. One active-low output-enable line is common to all devices and is pulsed for each read.

Device timing is given as picosecond parameters: clock period, address access, select access, output-enable access and bus float time. The block rounds each one up to whole clocks. For each read it delays output enable so that the shorter output-enable access ends together with the longer address or select access. It samples the bus at the first edge where every limit is met and returns the word with a single-cycle pulse. After a read, the selected device stays selected. A later read to that same device only changes the address. A read to a different device cannot drive output enable low until the previous device has had its float time to leave the bus.

Request side is valid/ready. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while no read is in progress. The host must hold `req_valid` and `req_addr` until the transfer. The response is a pulse with no back-pressure, so the host must always take `rsp_data` when `rsp_valid` is high.

Top module: `eprom_bank_rd`

## Requirements
- R1: The device index is the top SEL_W bits of `req_addr` and the word address is the low WORD_W bits. Bit i of `mem_ce_n` low selects device i. At most one bit of `mem_ce_n` is ever low, and after reset all bits are high.
- R2: After a read completes, the device it addressed keeps its `mem_ce_n` bit low until a request to another device is accepted. `mem_oe_n` is low only while some `mem_ce_n` bit is low.
- R3: `mem_oe_n` is high after reset and whenever the block is idle. It falls for each read at edge max(k+1, k+need−O), where k is the accept edge. The bus is sampled at edge max(k+need, oe_fall+O), and `mem_oe_n` rises at that same edge.
- R4: For a read to a device other than the last one read, `mem_oe_n` does not fall before edge r+D, where r is the edge at which `mem_oe_n` last rose. Two devices therefore never drive the bus at once.
- R5: need = A for a read to the same device as the previous read. For any other read, including the first after reset, need = max(A, C).
- R6: `rsp_valid` is high for exactly one cycle, the cycle after the sampling edge. `rsp_data` holds the bus value sampled at that edge.
- R7: `req_ready` is low from the accept edge until the sampling edge. It is high again in the `rsp_valid` cycle, so reads can run back to back.
- R8: A, C and O are the address, select and output-enable access times divided by CLK_PS and rounded up, with a minimum of 1. D is the float time divided by CLK_PS and rounded up, and may be 0.
- R9: `mem_addr` takes the word address at the accept edge and does not change until after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | SEL_W+WORD_W | Device index (top bits) and word address |
| rsp_valid | output | 1 | One-cycle pulse marking returned data |
| rsp_data | output | DATA_W | Word read |
| mem_addr | output | WORD_W | Shared address pins |
| mem_ce_n | output | 2**SEL_W | Per-device active-low chip select |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_data | input | DATA_W | Shared data bus |

## Verification
The bench models each device with cycle-level ages for the address, select and output enable. A device drives garbage until all three limits have passed, and it keeps counting as a driver for D cycles after it is disabled. A sequencer that samples one edge too early therefore returns a wrong word. One that switches devices too soon is reported as two drivers at once. The sweeps cover:
- runs to the same device, where a design that reapplied the select time would come back late;
- strict alternation between devices with no gap, where the float time decides the latency and an ungated output enable collides on the bus;
- alternation with long gaps, where only the rounded-up access counts should set the latency.

The sampling edge of every read is compared with the edge computed from R3 to R5.

// File: rtl/eprc_pkg.sv
package eprc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } rd_state_e;

  // Whole clocks covering a time, rounded up, never below floor_v.
  function automatic int clk_count(input int t_ps, input int clk_ps, input int floor_v);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < floor_v) ? floor_v : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprc_select.sv
module eprc_select #(
  parameter int SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [SEL_W-1:0]         dev,
  output logic [(1<<SEL_W)-1:0]    ce_n,
  output logic [SEL_W-1:0]         cur_dev,
  output logic                     cur_vld
);
  localparam int NUM_DEV = 1 << SEL_W;

  logic [NUM_DEV-1:0] ce_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_dev <= '0;
      cur_vld <= 1'b0;
    end else if (load) begin
      cur_dev <= dev;
      cur_vld <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_ce
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ce_n_q[g] <= 1'b1;
      else if (load) ce_n_q[g] <= (dev != SEL_W'(g));
    end
  end

  assign ce_n = ce_n_q;

  AST_CE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n_q)); // R1

  AST_CE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ce_n_q[cur_dev] == 1'b0)); // R2

endmodule

// File: rtl/eprc_access_timer.sv
module eprc_access_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             oe_n,
  output logic [CNT_W-1:0] addr_age,
  output logic [CNT_W-1:0] oe_age
);
  localparam logic [CNT_W-1:0] SAT = '1;

  // addr_age: clocks since the accept edge; oe_age: clocks since OE fell.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_age <= '0;
    end else if (start) begin
      addr_age <= '0;
    end else if (run && addr_age != SAT) begin
      addr_age <= addr_age + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_age <= '0;
    end else if (oe_n) begin
      oe_age <= '0;
    end else if (oe_age != SAT) begin
      oe_age <= oe_age + 1'b1;
    end
  end

endmodule

// File: rtl/eprc_release_timer.sv
module eprc_release_timer #(
  parameter int LOAD_V = 5,
  parameter int CNT_W  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic clear
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(LOAD_V);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign clear = (cnt_q == '0);

  AST_REL_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/eprom_bank_rd.sv
module eprom_bank_rd
  import eprc_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int WORD_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 5000,
  parameter int T_ACC_PS = 35000,
  parameter int T_CE_PS  = 35000,
  parameter int T_OE_PS  = 20000,
  parameter int T_DF_PS  = 30000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [SEL_W+WORD_W-1:0]   req_addr,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_data,
  output logic [WORD_W-1:0]         mem_addr,
  output logic [(1<<SEL_W)-1:0]     mem_ce_n,
  output logic                      mem_oe_n,
  input  logic [DATA_W-1:0]         mem_data
);
  localparam int NUM_DEV   = 1 << SEL_W;
  localparam int ADDR_W    = SEL_W + WORD_W;
  localparam int A_CNT     = clk_count(T_ACC_PS, CLK_PS, 1);
  localparam int C_CNT     = clk_count(T_CE_PS,  CLK_PS, 1);
  localparam int O_CNT     = clk_count(T_OE_PS,  CLK_PS, 1);
  localparam int D_CNT     = clk_count(T_DF_PS,  CLK_PS, 0);
  localparam int NEED_SAME = A_CNT;
  localparam int NEED_NEW  = imax(A_CNT, C_CNT);
  localparam int LEAD_SAME = imax(NEED_SAME - O_CNT, 1);
  localparam int LEAD_NEW  = imax(NEED_NEW - O_CNT, 1);
  localparam int REL_LOAD  = imax(D_CNT - 1, 0);
  localparam int MAX_CNT   = imax(imax(NEED_NEW, O_CNT), REL_LOAD) + 1;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] NEED_SAME_M1 = CNT_W'(NEED_SAME - 1);
  localparam logic [CNT_W-1:0] NEED_NEW_M1  = CNT_W'(NEED_NEW - 1);
  localparam logic [CNT_W-1:0] LEAD_SAME_M1 = CNT_W'(LEAD_SAME - 1);
  localparam logic [CNT_W-1:0] LEAD_NEW_M1  = CNT_W'(LEAD_NEW - 1);
  localparam logic [CNT_W-1:0] OE_M1        = CNT_W'(O_CNT - 1);

  rd_state_e          state_q;
  logic               same_q;
  logic               oe_n_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;
  logic [WORD_W-1:0]  addr_q;

  logic               accept;
  logic               in_access;
  logic               oe_fire;
  logic               capture;
  logic               rel_clear;
  logic [CNT_W-1:0]   addr_age;
  logic [CNT_W-1:0]   oe_age;
  logic [CNT_W-1:0]   need_m1;
  logic [CNT_W-1:0]   lead_m1;
  logic [SEL_W-1:0]   req_dev;
  logic [WORD_W-1:0]  req_word;
  logic [SEL_W-1:0]   cur_dev;
  logic               cur_vld;

  assign req_dev   = req_addr[ADDR_W-1 -: SEL_W];
  assign req_word  = req_addr[WORD_W-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_access = (state_q == ST_ACCESS);

  // The bus must settle for the full access; OE is held back so its own
  // shorter access ends at the same edge.
  always_comb begin
    need_m1 = same_q ? NEED_SAME_M1 : NEED_NEW_M1;
    lead_m1 = same_q ? LEAD_SAME_M1 : LEAD_NEW_M1;
  end

  assign oe_fire = in_access && oe_n_q && (addr_age >= lead_m1) && (same_q || rel_clear);
  assign capture = in_access && !oe_n_q && (addr_age >= need_m1) && (oe_age >= OE_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      same_q      <= 1'b0;
      oe_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      addr_q      <= '0;
    end else begin
      rsp_valid_q <= capture;
      if (accept) begin
        state_q <= ST_ACCESS;
        addr_q  <= req_word;
        same_q  <= cur_vld && (cur_dev == req_dev);
      end
      if (oe_fire) begin
        oe_n_q <= 1'b0;
      end
      if (capture) begin
        oe_n_q     <= 1'b1;
        state_q    <= ST_IDLE;
        rsp_data_q <= mem_data;
      end
    end
  end

  eprc_select #(
    .SEL_W (SEL_W)
  ) u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .dev     (req_dev),
    .ce_n    (mem_ce_n),
    .cur_dev (cur_dev),
    .cur_vld (cur_vld)
  );

  eprc_access_timer #(
    .CNT_W (CNT_W)
  ) u_access (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .run      (in_access),
    .oe_n     (oe_n_q),
    .addr_age (addr_age),
    .oe_age   (oe_age)
  );

  eprc_release_timer #(
    .LOAD_V (REL_LOAD),
    .CNT_W  (CNT_W)
  ) u_release (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (capture),
    .clear (rel_clear)
  );

  assign mem_addr  = addr_q;
  assign mem_oe_n  = oe_n_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  AST_SWITCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe_n_q) && !same_q) |-> $past(rel_clear)); // R4

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> (mem_ce_n != {NUM_DEV{1'b1}})); // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |=> !rsp_valid_q); // R6

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> oe_n_q); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |=> $stable(addr_q)); // R9

  AST_OE_WAITS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_q && !in_access) |-> 1'b0 || oe_n_q); // R3

endmodule

// File: tb/eprom_bank_rd_tb.sv
`timescale 1ns/1ps
module eprom_bank_rd_tb;
  localparam int SEL_W   = 2;
  localparam int WORD_W  = 4;
  localparam int DATA_W  = 16;
  localparam int CLK_PS  = 5000;
  localparam int TACC    = 35000;
  localparam int TCE     = 45000;
  localparam int TOE     = 20000;
  localparam int TDF     = 40000;
  localparam int NUM_DEV = 1 << SEL_W;
  localparam int NWORD   = 1 << WORD_W;
  localparam int A = (TACC + CLK_PS - 1) / CLK_PS;
  localparam int C = (TCE  + CLK_PS - 1) / CLK_PS;
  localparam int O = (TOE  + CLK_PS - 1) / CLK_PS;
  localparam int D = (TDF  + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic req_ready;
  logic [SEL_W+WORD_W-1:0] req_addr;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [WORD_W-1:0] mem_addr;
  logic [NUM_DEV-1:0] mem_ce_n;
  logic mem_oe_n;
  logic [DATA_W-1:0] mem_data;

  eprom_bank_rd #(
    .SEL_W(SEL_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .CLK_PS(CLK_PS),
    .T_ACC_PS(TACC), .T_CE_PS(TCE), .T_OE_PS(TOE), .T_DF_PS(TDF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_data(mem_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic [DATA_W-1:0] word_val(input int d, input int w);
    return DATA_W'(((d * NWORD) + w) * 241 + 4660);
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-level device models on the shared bus, updated between edges.
  int a_age;
  logic [WORD_W-1:0] last_addr;
  int oe_age;
  bit oe_was;
  int ce_age [NUM_DEV];
  bit ce_was [NUM_DEV];
  int hold [NUM_DEV];
  int clash = 0;
  int ce_bad = 0;

  always @(negedge clk) begin
    int drivers;
    int en_cnt;
    int en_dev;
    if (!rst_n) begin
      a_age = 0; last_addr = '0; oe_age = 0; oe_was = 0;
      for (int d = 0; d < NUM_DEV; d++) begin
        ce_age[d] = 0; ce_was[d] = 0; hold[d] = 0;
      end
      mem_data = 16'hFFFF;
    end else begin
      a_age = (mem_addr != last_addr) ? 0 : a_age + 1;
      last_addr = mem_addr;
      oe_age = mem_oe_n ? 0 : (oe_was ? oe_age + 1 : 0);
      oe_was = !mem_oe_n;
      if ($countones(~mem_ce_n) > 1) ce_bad++;
      drivers = 0; en_cnt = 0; en_dev = 0;
      for (int d = 0; d < NUM_DEV; d++) begin
        ce_age[d] = mem_ce_n[d] ? 0 : (ce_was[d] ? ce_age[d] + 1 : 0);
        ce_was[d] = !mem_ce_n[d];
        if (!mem_ce_n[d] && !mem_oe_n) begin
          hold[d] = D; drivers++; en_cnt++; en_dev = d;
        end else if (hold[d] > 0) begin
          drivers++; hold[d]--;
        end
      end
      if (drivers > 1) clash++;
      mem_data = 16'hFFFF;
      if (en_cnt == 1 && drivers == 1 && a_age + 1 >= A &&
          ce_age[en_dev] + 1 >= C && oe_age + 1 >= O)
        mem_data = word_val(en_dev, int'(mem_addr));
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  bit prev_vld = 0;
  int prev_dev = 0;
  int last_cap = -1000;

  task automatic do_read(input int dev, input int w, input int gap);
    int k, n, cap, need, oe_f, exp_cap;
    bit same, busy_ok, addr_ok;
    string tag;
    repeat (gap) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {dev[SEL_W-1:0], w[WORD_W-1:0]};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    k = cyc;
    req_valid = 1'b0;
    same = prev_vld && (prev_dev == dev);
    need = same ? A : mx(A, C);
    oe_f = mx(k + 1, k + need - O);
    if (!same) oe_f = mx(oe_f, last_cap + D);
    exp_cap = mx(k + need, oe_f + O);
    if (same) tag = "R5";
    else if (last_cap + D + O > k + need) tag = "R4";
    else tag = "R8";
    busy_ok = 1; addr_ok = 1; n = 0;
    while (!rsp_valid && n < 500) begin
      if (req_ready) busy_ok = 0;
      if (mem_addr != w[WORD_W-1:0]) addr_ok = 0;
      @(negedge clk);
      n++;
    end
    cap = cyc;
    check(cap == exp_cap, tag, cap - k, exp_cap - k);               // R3 R4 R5 R8 latency
    check(rsp_data == word_val(dev, w), "R6", int'(rsp_data), int'(word_val(dev, w)));
    check(busy_ok, "R7", 0, 1);
    check(addr_ok, "R9", 0, 1);
    check(mem_ce_n == ~(NUM_DEV'(1) << dev), "R2", int'(mem_ce_n), int'(~(NUM_DEV'(1) << dev)));
    check(mem_oe_n == 1'b1 && req_ready == 1'b1, "R3", int'(mem_oe_n), 1);
    prev_vld = 1; prev_dev = dev; last_cap = cap;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n == '1, "R1", int'(mem_ce_n), NUM_DEV'('1));
    check(mem_oe_n == 1'b1, "R3", int'(mem_oe_n), 1);
    check(req_ready == 1'b1, "R7", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R6", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Runs to one device at a time (same-device path, R5).
    for (int d = 0; d < NUM_DEV; d++)
      for (int w = 0; w < NWORD; w++) do_read(d, w, 0);
    // Alternating devices back to back (float-time gating, R4).
    for (int w = 0; w < NWORD; w++)
      for (int d = 0; d < NUM_DEV; d++) do_read(d, (w * 5 + 3) % NWORD, 0);
    // Alternating devices with idle gaps (rounded counts only, R8).
    for (int w = 0; w < NWORD / 2; w++)
      for (int d = NUM_DEV - 1; d >= 0; d--) do_read(d, w, 12);
    // Same word read twice in a row.
    for (int w = 0; w < 4; w++) begin
      do_read(w % NUM_DEV, NWORD - 1 - w, 0);
      do_read(w % NUM_DEV, NWORD - 1 - w, 1);
    end
    check(clash == 0, "R4", clash, 0);
    check(ce_bad == 0, "R1", ce_bad, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule